// File: doc/BRIEF.md
# Sticky Interrupt Aggregation Controller

This block gathers event sources into one interrupt line for a host. Each source owns a sticky flag bit and an enable bit. A flag stays set after its event is gone. The interrupt output is high while any flag is set and its enable bit is also set. Software clears a flag by writing a one to that bit. Writing a zero to a bit leaves it unchanged.

There are two kinds of source:
- Single-cycle pulse inputs, synchronous to the block clock. Typical pulse events are: a finished table upload, a key list that is ready, a completed authentication, and a full audio buffer.
- Two asynchronous level inputs: sink attachment and receiver presence. Each level input passes through a two-flop synchronizer. Any change of the synchronized level, rising or falling, raises that source's flag. The synchronized levels can also be read as live status bits.

A small register port gives access to the flags, the enables and the status. Writes are synchronous. Reads are combinational from the address.

The register map is:

| Address | Content | Access |
|---|---|---|
| 0 | Flags | Write one to clear |
| 1 | Enables | Read/write |
| 2 | Status | Read-only |

Flag and enable bits share one layout:
- Bit 0 is attach.
- Bit 1 is receiver-sense.
- Bits 2 and up are pulse input `evt_i[k]` at bit k+2.

In the status word, bit 0 is the synchronized attach level and bit 1 is the synchronized receiver-sense level. Bits above the sources read as zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all flags, all enables, both status bits and `irq_o` are 0.
- R2: A high `evt_i[k]` at a clock edge sets flag bit k+2 at that edge. If that bit is enabled, `irq_o` goes high at the same edge.
- R3: A rising or a falling change on a level input sets its flag at the third clock edge after the change. For attach this is bit 0; for receiver-sense it is bit 1. A level that stays constant sets nothing more.
- R4: Status bit 0 and status bit 1 show the attach and receiver-sense levels. Each is readable from the second clock edge after the level changes.
- R5: Writing to address 0 clears every flag bit written as one. Every flag bit written as zero keeps its value.
- R6: When an event and a clearing write hit the same flag bit in the same cycle, the flag stays set.
- R7: `irq_o` stays high until every enabled pending flag has been cleared. It cannot drop in a cycle with no register write.
- R8: Flags are set whether or not their source is enabled. When every enable is 0, `irq_o` is 0. Clearing the enable of a pending source drops `irq_o` and leaves the flag set.
- R9: The enable register at address 1 reads back the written source bits, with unused upper bits read as 0. Writes to address 2 have no effect. Address 3 reads as 0.
- R10: `irq_o` is a register. It reflects flag and enable updates at the same edge that makes those updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Single-cycle pulse event sources |
| attach_lvl_i | input | 1 | Asynchronous sink-attach level |
| rxsense_lvl_i | input | 1 | Asynchronous receiver-sense level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The assertions check the following on every cycle:
- Flag stickiness when no clearing write is made.
- The set that follows a pulse or a synchronized edge, including when a clearing write hits the same bit in the same cycle.
- That `irq_o` cannot fall in a cycle without a write.
- That `irq_o` is low whenever all enables are zero.

Other behaviour can only be shown by the bench scenarios:
- The exact latency of the synchronizer.
- The clearing of several flags one by one while the interrupt stays high.
- The read-back of the enables and the status.
- That status writes are ignored and unmapped reads return zero.
- The drop of the interrupt when an enable is cleared while its flag is left pending.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_EVT = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              attach_lvl_i,
  input  logic              rxsense_lvl_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int NSRC = NUM_EVT + 2;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  logic [1:0] sync1_q, sync2_q, prev_q;
  logic [NSRC-1:0] flag_q, en_q, flag_d, en_d;
  logic irq_q;

  wire [1:0] lvl_edge = sync2_q ^ prev_q;
  wire [NSRC-1:0] set_vec = {evt_i, lvl_edge};
  wire wr_flag = wr_en_i && (wr_addr_i == A_FLAG);
  wire wr_en   = wr_en_i && (wr_addr_i == A_EN);
  wire [NSRC-1:0] clr_vec = wr_flag ? wr_data_i[NSRC-1:0] : '0;

  assign flag_d = (flag_q & ~clr_vec) | set_vec;
  assign en_d   = wr_en ? wr_data_i[NSRC-1:0] : en_q;

  generate
    if (DATA_W > NSRC) begin : g_pad
      wire unused_hi = ^wr_data_i[DATA_W-1:NSRC];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      flag_q  <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      sync1_q <= {rxsense_lvl_i, attach_lvl_i};
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      flag_q  <= flag_d;
      en_q    <= en_d;
      irq_q   <= |(flag_d & en_d);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_FLAG:  rd_data_o[NSRC-1:0] = flag_q;
      A_EN:    rd_data_o[NSRC-1:0] = en_q;
      A_STAT:  rd_data_o[1:0]      = sync2_q;
      default: rd_data_o = '0;
    endcase
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_q[i] && !(wr_flag && wr_data_i[i]) |=> flag_q[i]);
      assert_event_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_vec[i] && clr_vec[i] |=> flag_q[i]);
    end
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
      assert_pulse_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[k] |=> flag_q[k+2]);
    end
    for (genvar j = 0; j < 2; j++) begin : g_lvl
      assert_edge_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_edge[j] |=> flag_q[j]);
    end
  endgenerate

  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !wr_en_i |=> irq_o);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  localparam int NUM_EVT = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_EVT-1:0] evt = '0;
  logic attach = 1'b0, rxs = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic irq;

  always #10 clk = ~clk;

  irq_aggregator #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .attach_lvl_i(attach),
    .rxsense_lvl_i(rxs), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));

  typedef struct { string req; bit is_irq; logic [7:0] exp; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic idle_inputs();
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic step();
    @(negedge clk); idle_inputs();
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); idle_inputs();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] m);
    @(negedge clk); idle_inputs(); evt = m;
  endtask

  task automatic wr_pulse(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                          input logic [NUM_EVT-1:0] m);
    @(negedge clk); idle_inputs();
    wr_en = 1'b1; wr_addr = a; wr_data = d; evt = m;
  endtask

  task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string r);
    item_t it;
    @(negedge clk); idle_inputs(); rd_addr = a;
    it.req = r; it.is_irq = 1'b0; it.exp = e; q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    @(negedge clk); idle_inputs();
    it.req = r; it.is_irq = 1'b1; it.exp = {7'd0, e}; q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] act;
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        it = q.pop_front();
        act = it.is_irq ? {7'd0, irq} : rd_data;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s: actual=%h expected=%h", it.req,
                   it.is_irq ? "irq" : "read", act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(0, 8'h00, "R1");
    chk_rd(1, 8'h00, "R1");
    chk_rd(2, 8'h00, "R1");
    chk_irq(1'b0, "R1");
    // R9 enable readback, upper bits zero
    wr(1, 8'hFF);
    chk_rd(1, 8'h3F, "R9");
    // R2 / R10 pulse sets flag and irq at same edge
    pulse(4'b0001);
    chk_irq(1'b1, "R10");
    chk_rd(0, 8'h04, "R2");
    pulse(4'b1000);
    chk_rd(0, 8'h24, "R2");
    // R5 / R7 write-one-to-clear, irq held
    wr(0, 8'h04);
    chk_rd(0, 8'h20, "R5");
    chk_irq(1'b1, "R7");
    wr(0, 8'h00);
    chk_rd(0, 8'h20, "R5");
    wr(0, 8'h20);
    chk_rd(0, 8'h00, "R5");
    chk_irq(1'b0, "R7");
    // R6 event beats same-cycle clear
    pulse(4'b0010);
    wr_pulse(0, 8'h08, 4'b0010);
    chk_rd(0, 8'h08, "R6");
    wr(0, 8'h08);
    chk_rd(0, 8'h00, "R6");
    // R8 enable gating
    wr(1, 8'h00);
    pulse(4'b0001);
    chk_rd(0, 8'h04, "R8");
    chk_irq(1'b0, "R8");
    wr(1, 8'h04);
    chk_irq(1'b1, "R8");
    wr(1, 8'h00);
    chk_irq(1'b0, "R8");
    chk_rd(0, 8'h04, "R8");
    wr(0, 8'h04);
    wr(1, 8'h3F);
    // R3 / R4 attach rising edge
    @(negedge clk); idle_inputs(); attach = 1'b1;
    step();
    chk_rd(2, 8'h01, "R4");
    chk_rd(0, 8'h01, "R3");
    chk_irq(1'b1, "R3");
    wr(0, 8'h01);
    step(); step();
    chk_rd(0, 8'h00, "R3");
    // R3 attach falling edge
    @(negedge clk); idle_inputs(); attach = 1'b0;
    step();
    chk_rd(2, 8'h00, "R4");
    chk_rd(0, 8'h01, "R3");
    wr(0, 8'h01);
    // R3 / R4 receiver-sense
    @(negedge clk); idle_inputs(); rxs = 1'b1;
    step();
    chk_rd(2, 8'h02, "R4");
    chk_rd(0, 8'h02, "R3");
    // R9 status write ignored, unmapped read zero
    wr(2, 8'h00);
    chk_rd(2, 8'h02, "R9");
    chk_rd(3, 8'h00, "R9");
    wr(0, 8'h02);
    chk_rd(0, 8'h00, "R5");
    chk_irq(1'b0, "R7");
    step(); step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule